// File: doc/BRIEF.md
# Host-Side Parallel Byte Port

This block lets an external microprocessor treat an 8-bit location inside the chip as a plain latch. The host uses three active-low pins: a select, a read strobe and a write strobe. It can deposit a byte into an inbound latch or fetch a byte from an outbound latch. It does this at its own pace, with no shared clock. The internal processor sees the inbound byte, loads the outbound byte, and is told about host activity through status flags and a sticky interrupt flag.

The host pins are asynchronous. They pass through a chain of flip-flops before any edge decision is made. A host transaction is recognised once, on the first synchronised sample in which select and the relevant strobe are both low. It is treated as finished when that condition goes away. The bus output-enable is decoded straight from the pins, so that a host read sees data with no clock delay. Pad drivers are outside the block. The block only provides the data, its enable and the captured input byte.

Top module: `host_slave_port`

## Requirements
- R1: During and right after reset, all four flags are 0, both latches hold 0 and `host_data_oe` is 0.
- R2: While `mode_en` is 0, the host pins have no effect. No latch or flag changes because of them, and `host_data_oe` stays 0.
- R3: `host_data_oe` is 1 exactly when `mode_en` is 1 and `host_cs_n` and `host_rd_n` are both 0, with no clock delay. `host_data_out` shows the outbound latch while `host_data_oe` is 1 and is 0 otherwise.
- R4: At the start of a host write, `host_data_in` is stored in the inbound latch (visible on `cpu_in_data`) and `in_full` becomes 1. A one-cycle `cpu_rd_in` pulse clears `in_full`. A write start in the same cycle wins over that clear.
- R5: `overflow` becomes 1 when a host write starts while `in_full` is already 1 and `cpu_rd_in` is 0 in that cycle.
- R6: A `cpu_wr_out` pulse loads `cpu_wdata` into the outbound latch and sets `out_full`. The end of a host read clears `out_full`. A CPU write in the same cycle wins.
- R7: `irq` becomes 1 at the end of each host write or host read. It stays 1 until a `cpu_clr_flags` pulse, which also clears `overflow`. A new event in the same cycle as the clear wins.
- R8: The pins pass through two flip-flop stages by default, so a transaction start changes the flags on the third rising edge after the pins go low. A transaction held low for many cycles is detected only once.
- R9: If `mode_en` falls while a host transaction is in progress, no end event is produced and `irq` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables the host port |
| host_cs_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_data_in | input | 8 | Byte driven by the host |
| host_data_out | output | 8 | Outbound byte towards the pads |
| host_data_oe | output | 1 | Pad drive enable |
| cpu_rd_in | input | 1 | CPU has consumed the inbound byte |
| cpu_in_data | output | 8 | Inbound latch contents |
| cpu_wr_out | input | 1 | CPU write strobe for the outbound latch |
| cpu_wdata | input | 8 | Byte written by the CPU |
| cpu_clr_flags | input | 1 | Clears irq and overflow |
| in_full | output | 1 | Inbound byte not yet consumed |
| out_full | output | 1 | Outbound byte not yet fetched |
| overflow | output | 1 | Inbound byte overwritten before consumption |
| irq | output | 1 | Sticky host-activity interrupt |

## Verification
The hardest case to reach is the interaction between the synchroniser delay and the CPU side. One example is a CPU read or clear that lands on the very edge where a delayed host event takes effect. Another is a mode drop while the host still holds a strobe low. The stimulus counts edges from the pin change so that `cpu_rd_in` and `cpu_clr_flags` fall on those exact cycles. It also holds a strobe low across a CPU read to show there is no second detection. A behavioural model, fed the same pins, is compared on every cycle.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    typedef struct packed {
        logic wr_start;
        logic wr_end;
        logic rd_start;
        logic rd_end;
    } events_t;

    typedef struct packed {
        logic in_full;
        logic out_full;
        logic overflow;
        logic irq;
    } flags_t;

    function automatic logic port_hit(input logic en, input logic sel_n, input logic strb_n);
        return en & ~sel_n & ~strb_n;
    endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync
    import hsp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  strobes_t raw,
    output strobes_t synced
);
    localparam int W = $bits(strobes_t);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= STROBES_IDLE;
        else     chain[0] <= raw;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= STROBES_IDLE;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign synced = strobes_t'(chain[STAGES-1]);
endmodule

// File: rtl/hsp_detect.sv
module hsp_detect
    import hsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mode_en,
    input  strobes_t s,
    output events_t  ev
);
    logic wr_act, rd_act, wr_q, rd_q;

    assign wr_act = port_hit(mode_en, s.cs_n, s.wr_n);
    assign rd_act = port_hit(mode_en, s.cs_n, s.rd_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    always_comb begin
        ev.wr_start = wr_act & ~wr_q;
        ev.rd_start = rd_act & ~rd_q;
        ev.wr_end   = mode_en & wr_q & ~wr_act;
        ev.rd_end   = mode_en & rd_q & ~rd_act;
    end

    p_single_start_r8: assert property (@(posedge clk) disable iff (rst)
        ev.wr_start |=> !ev.wr_start);
    p_no_events_off_r2: assert property (@(posedge clk) disable iff (rst)
        !mode_en |-> !(ev.wr_start || ev.rd_start || ev.wr_end || ev.rd_end));
endmodule

// File: rtl/hsp_regs.sv
module hsp_regs
    import hsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  events_t       ev,
    input  logic [DW-1:0] host_data_in,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_clr,
    output logic [DW-1:0] in_latch,
    output logic [DW-1:0] out_latch,
    output flags_t        flags
);
    flags_t flags_n;

    always_comb begin
        flags_n = flags;
        if (ev.wr_start)  flags_n.in_full = 1'b1;
        else if (cpu_rd)  flags_n.in_full = 1'b0;

        if (ev.wr_start && flags.in_full && !cpu_rd) flags_n.overflow = 1'b1;
        else if (cpu_clr)                            flags_n.overflow = 1'b0;

        if (cpu_wr)         flags_n.out_full = 1'b1;
        else if (ev.rd_end) flags_n.out_full = 1'b0;

        if (ev.wr_end || ev.rd_end) flags_n.irq = 1'b1;
        else if (cpu_clr)           flags_n.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            in_latch  <= '0;
            out_latch <= '0;
        end else begin
            flags <= flags_n;
            if (ev.wr_start) in_latch  <= host_data_in;
            if (cpu_wr)      out_latch <= cpu_wdata;
        end
    end

    p_full_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        ev.wr_start |=> flags.in_full);
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.overflow) |-> $past(flags.in_full));
    p_out_full_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |=> flags.out_full);
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flags.irq && !cpu_clr) |=> flags.irq);
endmodule

// File: rtl/host_slave_port.sv
module host_slave_port
    import hsp_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_en,
    input  logic          host_cs_n,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [DW-1:0] host_data_in,
    output logic [DW-1:0] host_data_out,
    output logic          host_data_oe,
    input  logic          cpu_rd_in,
    output logic [DW-1:0] cpu_in_data,
    input  logic          cpu_wr_out,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_clr_flags,
    output logic          in_full,
    output logic          out_full,
    output logic          overflow,
    output logic          irq
);
    strobes_t      raw, synced;
    events_t       ev;
    flags_t        flags;
    logic [DW-1:0] out_latch;

    assign raw = '{cs_n: host_cs_n, rd_n: host_rd_n, wr_n: host_wr_n};

    hsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw), .synced(synced)
    );

    hsp_detect u_detect (
        .clk(clk), .rst(rst), .mode_en(mode_en), .s(synced), .ev(ev)
    );

    hsp_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .ev(ev), .host_data_in(host_data_in),
        .cpu_rd(cpu_rd_in), .cpu_wr(cpu_wr_out), .cpu_wdata(cpu_wdata),
        .cpu_clr(cpu_clr_flags), .in_latch(cpu_in_data),
        .out_latch(out_latch), .flags(flags)
    );

    assign host_data_oe  = port_hit(mode_en, host_cs_n, host_rd_n);
    assign host_data_out = host_data_oe ? out_latch : '0;
    assign in_full       = flags.in_full;
    assign out_full      = flags.out_full;
    assign overflow      = flags.overflow;
    assign irq           = flags.irq;

    always_comb begin
        if (!rst) p_oe_needs_mode_r3: assert (!host_data_oe || mode_en);
    end
endmodule

// File: tb/host_slave_port_bench.sv
module host_slave_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_en = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       oe;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_in;
    logic       cpu_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       clr = 1'b0;
    logic       in_full, out_full, overflow, irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    host_slave_port u_host_slave_port (
        .clk(clk), .rst(rst), .mode_en(mode_en),
        .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_data_in(din), .host_data_out(dout), .host_data_oe(oe),
        .cpu_rd_in(cpu_rd), .cpu_in_data(cpu_in), .cpu_wr_out(cpu_wr),
        .cpu_wdata(wdata), .cpu_clr_flags(clr),
        .in_full(in_full), .out_full(out_full), .overflow(overflow), .irq(irq)
    );

    // behavioural reference
    bit [2:0] h0, h1;          // pin samples {cs,rd,wr}: last edge, two edges ago
    bit       m_wq, m_rq;
    bit [7:0] m_in, m_out;
    bit       m_inf, m_outf, m_ovf, m_irq;

    always @(posedge clk) begin
        if (rst) begin
            h0 = 3'b111; h1 = 3'b111; m_wq = 0; m_rq = 0;
            m_in = 0; m_out = 0; m_inf = 0; m_outf = 0; m_ovf = 0; m_irq = 0;
        end else begin
            bit wa, ra, ws, we, re;
            wa = mode_en && !h1[2] && !h1[0];
            ra = mode_en && !h1[2] && !h1[1];
            ws = wa && !m_wq;
            we = mode_en && m_wq && !wa;
            re = mode_en && m_rq && !ra;
            if (ws && m_inf && !cpu_rd) m_ovf = 1; else if (clr) m_ovf = 0;
            if (ws) begin m_inf = 1; m_in = din; end else if (cpu_rd) m_inf = 0;
            if (cpu_wr) begin m_outf = 1; m_out = wdata; end else if (re) m_outf = 0;
            if (we || re) m_irq = 1; else if (clr) m_irq = 0;
            m_wq = wa; m_rq = ra;
            h1 = h0; h0 = {cs_n, rd_n, wr_n};
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            bit e_oe;
            e_oe = mode_en && !cs_n && !rd_n;
            chk("R3 oe", oe, e_oe);
            chk("R3 data_out", dout, e_oe ? m_out : 0);
            chk("R4 in_full", in_full, m_inf);
            chk("R4 cpu_in_data", cpu_in, m_in);
            chk("R5 overflow", overflow, m_ovf);
            chk("R6 out_full", out_full, m_outf);
            chk("R7 irq", irq, m_irq);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] b);
        din = b; cs_n = 0; wr_n = 0; cyc(5);
        wr_n = 1; cs_n = 1; cyc(5);
    endtask

    task automatic host_read();
        cs_n = 0; rd_n = 0; cyc(5);
        rd_n = 1; cs_n = 1; cyc(5);
    endtask

    task automatic pulse_rd();  cpu_rd = 1; cyc(1); cpu_rd = 0; endtask
    task automatic pulse_clr(); clr = 1;    cyc(1); clr = 0;    endtask
    task automatic cpu_write(input logic [7:0] b);
        wdata = b; cpu_wr = 1; cyc(1); cpu_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 in_full", in_full, 0); chk("R1 irq", irq, 0);
        chk("R1 oe", oe, 0); chk("R1 cpu_in_data", cpu_in, 0);
        rst = 0; cyc(2);
        chk("R1 out_full", out_full, 0); chk("R1 overflow", overflow, 0);

        // R2 mode off: host write/read ignored
        host_write(8'hA5); host_read();
        chk("R2 in_full", in_full, 0); chk("R2 irq", irq, 0);
        chk("R2 cpu_in_data", cpu_in, 0);
        cs_n = 0; rd_n = 0; #1 chk("R2 oe", oe, 0); cyc(1); cs_n = 1; rd_n = 1; cyc(3);

        mode_en = 1; cyc(2);
        // R8 latency: pins low before edge E1, flags move at E3
        din = 8'h3C; cs_n = 0; wr_n = 0;
        cyc(2); chk("R8 not yet", in_full, 0);
        cyc(1); chk("R8 start", in_full, 1); chk("R4 byte", cpu_in, 8'h3C);
        // R8 single detect: consume while held low, no retrigger
        pulse_rd(); cyc(4); chk("R8 no retrigger", in_full, 0);
        wr_n = 1; cs_n = 1; cyc(4); chk("R7 irq after write", irq, 1);
        pulse_clr(); chk("R7 cleared", irq, 0);

        // R5 overflow
        host_write(8'h11); host_write(8'h22);
        chk("R5 overflow set", overflow, 1); chk("R4 last byte", cpu_in, 8'h22);
        pulse_rd(); pulse_clr(); chk("R5 overflow cleared", overflow, 0);

        // R4/R5 CPU read on the write-start edge: no overflow
        host_write(8'h33);
        din = 8'h44; cs_n = 0; wr_n = 0; cyc(2);
        cpu_rd = 1; cyc(1); cpu_rd = 0;
        chk("R5 same-cycle read", overflow, 0); chk("R4 start wins", in_full, 1);
        wr_n = 1; cs_n = 1; cyc(5); pulse_rd(); pulse_clr();

        // R6 / R3 read path
        cpu_write(8'h5A); chk("R6 out_full", out_full, 1);
        cs_n = 0; rd_n = 0; #1 chk("R3 oe", oe, 1); chk("R3 data", dout, 8'h5A);
        cyc(5); rd_n = 1; cs_n = 1; #1 chk("R3 oe off", oe, 0);
        cyc(5); chk("R6 cleared by read", out_full, 0); chk("R7 irq read", irq, 1);

        // R7 set wins over clear on the same edge: end event at E3 after release
        cs_n = 0; wr_n = 0; din = 8'h66; cyc(5);
        wr_n = 1; cs_n = 1; cyc(2); clr = 1; cyc(1); clr = 0;
        chk("R7 set wins", irq, 1);
        pulse_clr(); pulse_rd();

        // R9 mode drop mid-write
        cs_n = 0; wr_n = 0; din = 8'h77; cyc(5);
        mode_en = 0; cyc(2); wr_n = 1; cs_n = 1; cyc(5);
        chk("R9 no irq", irq, 0);
        mode_en = 1; cyc(4);
        chk("R9 no spurious", irq, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule